// File: doc/BRIEF.md
# Multi-Port Link Error Status Register

This block gathers link error and diagnostic status for a controller with four serial storage links. Each link provides a PHY-ready level, a receive signal-detect level, and three single-cycle fault pulses: FIFO overrun or underrun, malformed received frame, and data-integrity fault. A data-integrity fault covers a CRC error, a disparity error, or an error primitive returned for a data frame. Each event sets a sticky bit in that link's 32-bit status word. Software clears a sticky bit by writing 1 to it.

The two level inputs pass through a two-flop synchronizer before any edge detection. The synchronizer resets to not-ready, so a link that is already ready when reset ends counts as a not-ready to ready transition. Five of the sticky bits of each link are copied into that link's 8-bit slot in a 32-bit interrupt-pending word, and each copy is gated by its own enable bit. The single interrupt output is the OR of the whole pending word.

Software uses one register port with a combinational read. Addresses 0 to 3 select the link status words, address 4 selects the pending word and address 5 selects the enable word.

Top module: `link_err_status`

## Requirements
- R1: Status bit 16 of a link sets when its synchronized PHY-ready changes in either direction. The bit is visible two clock edges after the edge that first samples the changed input.
- R2: Status bit 1 of a link sets only on a synchronized not-ready to ready change, with the same latency as R1. A ready to not-ready change leaves bit 1 alone. The synchronizer resets to not-ready, so an input that is high when reset ends sets bits 1 and 16.
- R3: Status bit 11 sets at the clock edge that samples a FIFO error pulse for that link.
- R4: Status bit 10 sets at the clock edge that samples a malformed-frame pulse for that link.
- R5: Status bit 8 sets at the clock edge that samples a data-integrity pulse for that link.
- R6: Status bit 9 equals the inverse of the synchronized signal-detect level, two edges after the input changes. Writing 1 to bit 9 has no lasting effect.
- R7: Bits 16, 11, 10, 8 and 1 are sticky and clear when a 1 is written to them at that link's address (address p for link p). Writing 0 has no effect. If an event and a clearing write land on the same edge, the bit stays set.
- R8: Every status bit resets to 0. Bits 31 to 17, 15 to 12, 7 to 2 and 0 always read 0.
- R9: Pending bit 8p+0 reflects link p's bit 16, 8p+1 its bit 1, 8p+2 its bit 11, 8p+4 its bit 10 and 8p+5 its bit 8. Each pending bit is the AND of that status bit and the matching enable bit.
- R10: The interrupt output is the OR of all pending bits. It is low whenever the enable word is 0.
- R11: Address 4 reads the pending word and ignores writes. Address 5 reads and writes the enable word; only the 20 mapped positions are writable and the rest read 0. The enable word resets to 0. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phy_rdy_i | input | 4 | PHY-ready level, one bit per link, asynchronous |
| sig_det_i | input | 4 | Receive signal-detect level, one bit per link, asynchronous |
| fifo_err_i | input | 4 | FIFO overrun/underrun pulse per link |
| frm_err_i | input | 4 | Malformed received frame pulse per link |
| integ_err_i | input | 4 | Data-integrity fault pulse per link |
| reg_we_i | input | 1 | Register write strobe, acts on the clock edge |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data; a 1 clears a sticky status bit |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A stale previous-ready flop shows up as a missing or extra bit 16 or bit 1 on the second edge after a level change. A lost clear, or a clear that wrongly beats a coincident event, shows up on the next read of that link's word right after the write edge. A misrouted slot or a wrong enable mask shows up immediately in the pending word and the interrupt output, because both are combinational from the registered status. Every register and the interrupt output are compared after every clock edge, so any divergence is caught within one cycle of the edge that causes it.

// File: rtl/link_err_pkg.sv
package link_err_pkg;

    localparam int unsigned STS_W  = 32;
    localparam int unsigned SLOT_W = 8;

    // status word bit positions
    localparam int unsigned B_RECOV = 1;
    localparam int unsigned B_INTEG = 8;
    localparam int unsigned B_NOSIG = 9;
    localparam int unsigned B_FRM   = 10;
    localparam int unsigned B_FIFO  = 11;
    localparam int unsigned B_CHG   = 16;

    // bits cleared by a 1 written to them
    localparam logic [STS_W-1:0] W1C_MASK  = STS_W'(32'h0001_0D02);
    // every bit that can ever read 1
    localparam logic [STS_W-1:0] IMPL_MASK = STS_W'(32'h0001_0F02);

    // positions inside one interrupt slot
    localparam int unsigned S_CHG   = 0;
    localparam int unsigned S_RECOV = 1;
    localparam int unsigned S_FIFO  = 2;
    localparam int unsigned S_FRM   = 4;
    localparam int unsigned S_INTEG = 5;
    localparam logic [SLOT_W-1:0] SLOT_MASK = SLOT_W'(8'h37);

    typedef struct packed {
        logic [STS_W-1:0] sts;
        logic             prev_rdy;
    } port_state_t;

endpackage

// File: rtl/link_err_sync.sv
module link_err_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = d_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/link_err_port.sv
module link_err_port
    import link_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rdy_s,
    input  logic              sdet_s,
    input  logic              fifo_err_i,
    input  logic              frm_err_i,
    input  logic              integ_err_i,
    input  logic [STS_W-1:0]  clr_i,
    output logic [STS_W-1:0]  sts_o,
    output logic [SLOT_W-1:0] slot_o
);

    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sts = st_q.sts & ~(clr_i & W1C_MASK);
        // events are applied after the clear so they win on a collision
        if (rdy_s != st_q.prev_rdy) st_d.sts[B_CHG]   = 1'b1;
        if (rdy_s && !st_q.prev_rdy) st_d.sts[B_RECOV] = 1'b1;
        if (fifo_err_i)  st_d.sts[B_FIFO]  = 1'b1;
        if (frm_err_i)   st_d.sts[B_FRM]   = 1'b1;
        if (integ_err_i) st_d.sts[B_INTEG] = 1'b1;
        st_d.sts[B_NOSIG] = !sdet_s;
        st_d.prev_rdy = rdy_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o = st_q.sts;

    always_comb begin
        slot_o = '0;
        slot_o[S_CHG]   = st_q.sts[B_CHG];
        slot_o[S_RECOV] = st_q.sts[B_RECOV];
        slot_o[S_FIFO]  = st_q.sts[B_FIFO];
        slot_o[S_FRM]   = st_q.sts[B_FRM];
        slot_o[S_INTEG] = st_q.sts[B_INTEG];
    end

    // R1: any change of the synchronized level marks the change bit
    a_r1_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_s != st_q.prev_rdy) |=> st_q.sts[B_CHG]);

    // R2: rising level marks the recovered bit
    a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_s && !st_q.prev_rdy) |=> st_q.sts[B_RECOV]);

    // R2: a falling level never raises the recovered bit
    a_r2_fall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_s && !st_q.sts[B_RECOV]) |=> !st_q.sts[B_RECOV]);

    // R7: event wins over a same-edge clear
    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_err_i && clr_i[B_FIFO]) |=> st_q.sts[B_FIFO]);

    // R7: a clear with no event empties the bit
    a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[B_FRM] && !frm_err_i) |=> !st_q.sts[B_FRM]);

    // R6: no-signal bit follows the synchronized level
    a_r6_nosig_level: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.sts[B_NOSIG] == !$past(sdet_s)));

    // R8: reserved positions stay zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o & ~IMPL_MASK) == '0);

endmodule

// File: rtl/link_err_status.sv
module link_err_status
    import link_err_pkg::*;
#(
    parameter int unsigned NPORTS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NPORTS-1:0]                    phy_rdy_i,
    input  logic [NPORTS-1:0]                    sig_det_i,
    input  logic [NPORTS-1:0]                    fifo_err_i,
    input  logic [NPORTS-1:0]                    frm_err_i,
    input  logic [NPORTS-1:0]                    integ_err_i,
    input  logic                                 reg_we_i,
    input  logic [$clog2(NPORTS+2)-1:0]          reg_addr_i,
    input  logic [STS_W-1:0]                     reg_wdata_i,
    output logic [STS_W-1:0]                     reg_rdata_o,
    output logic                                 irq_o
);

    localparam int unsigned PEND_W    = SLOT_W * NPORTS;
    localparam int unsigned NREGS     = NPORTS + 2;
    localparam int unsigned ADDR_W    = $clog2(NREGS);
    localparam int unsigned ADDR_PEND = NPORTS;
    localparam int unsigned ADDR_EN   = NPORTS + 1;
    localparam logic [PEND_W-1:0] EN_VALID = {NPORTS{SLOT_MASK}};

    logic [NPORTS-1:0]             rdy_s, sdet_s;
    logic [NPORTS-1:0][STS_W-1:0]  sts;
    logic [PEND_W-1:0]             raw, pend;
    logic [PEND_W-1:0]             en_d, en_q;

    link_err_sync #(.W(NPORTS), .STAGES(2)) i_sync_rdy (
        .clk(clk), .rst_n(rst_n), .d_i(phy_rdy_i), .q_o(rdy_s));

    link_err_sync #(.W(NPORTS), .STAGES(2)) i_sync_sdet (
        .clk(clk), .rst_n(rst_n), .d_i(sig_det_i), .q_o(sdet_s));

    for (genvar p = 0; p < int'(NPORTS); p++) begin : g_port
        logic [STS_W-1:0] clr;
        assign clr = (reg_we_i && reg_addr_i == ADDR_W'(p)) ? reg_wdata_i : '0;

        link_err_port i_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .rdy_s       (rdy_s[p]),
            .sdet_s      (sdet_s[p]),
            .fifo_err_i  (fifo_err_i[p]),
            .frm_err_i   (frm_err_i[p]),
            .integ_err_i (integ_err_i[p]),
            .clr_i       (clr),
            .sts_o       (sts[p]),
            .slot_o      (raw[p*SLOT_W +: SLOT_W])
        );
    end

    always_comb begin
        en_d = en_q;
        if (reg_we_i && reg_addr_i == ADDR_W'(ADDR_EN)) begin
            en_d = reg_wdata_i[PEND_W-1:0] & EN_VALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign pend  = raw & en_q;
    assign irq_o = |pend;

    always_comb begin
        reg_rdata_o = '0;
        for (int p = 0; p < int'(NPORTS); p++) begin
            if (reg_addr_i == ADDR_W'(p)) reg_rdata_o = sts[p];
        end
        if (reg_addr_i == ADDR_W'(ADDR_PEND)) reg_rdata_o = STS_W'(pend);
        if (reg_addr_i == ADDR_W'(ADDR_EN))   reg_rdata_o = STS_W'(en_q);
    end

    // R10: nothing enabled means no request
    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o);

    // R11: enable write keeps only mapped positions
    a_r11_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == ADDR_W'(ADDR_EN))
        |=> (en_q == ($past(reg_wdata_i[PEND_W-1:0]) & EN_VALID)));

    // R9: pending never shows a disabled bit
    a_r9_pend_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~en_q) == '0);

endmodule

// File: tb/test_link_err_status.sv
module test_link_err_status;

    localparam int PERIOD   = 40;
    localparam int NP       = 4;
    localparam int NCYC     = 4000;
    localparam logic [31:0] W1C   = 32'h0001_0D02;
    localparam logic [31:0] ENMSK = 32'h3737_3737;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  phy_rdy = '0, sig_det = '0, fifo_err = '0, frm_err = '0, integ_err = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(PERIOD/2) clk = ~clk;

    link_err_status #(.NPORTS(NP)) i_link_err_status (
        .clk(clk), .rst_n(rst_n), .phy_rdy_i(phy_rdy), .sig_det_i(sig_det),
        .fifo_err_i(fifo_err), .frm_err_i(frm_err), .integ_err_i(integ_err),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq));

    // requirement model
    logic [3:0]  m_r1, m_r2, m_d1, m_d2, m_prev;
    logic [31:0] m_sts [NP];
    logic [31:0] m_en;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_r1 <= '0; m_r2 <= '0; m_d1 <= '0; m_d2 <= '0; m_prev <= '0; m_en <= '0;
            for (int p = 0; p < NP; p++) m_sts[p] <= '0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                logic [31:0] s;
                s = m_sts[p];
                if (reg_we && reg_addr == 3'(p)) s = s & ~(reg_wdata & W1C);  // R7
                if (m_r2[p] != m_prev[p]) s[16] = 1'b1;                      // R1
                if (m_r2[p] && !m_prev[p]) s[1] = 1'b1;                      // R2
                if (fifo_err[p])  s[11] = 1'b1;                              // R3
                if (frm_err[p])   s[10] = 1'b1;                              // R4
                if (integ_err[p]) s[8]  = 1'b1;                              // R5
                s[9] = !m_d2[p];                                             // R6
                m_sts[p] <= s;
            end
            m_prev <= m_r2; m_r2 <= m_r1; m_r1 <= phy_rdy;
            m_d2 <= m_d1;   m_d1 <= sig_det;
            if (reg_we && reg_addr == 3'd5) m_en <= reg_wdata & ENMSK;       // R11
        end
    end

    function automatic logic [31:0] exp_pend();
        logic [31:0] r = '0;
        for (int p = 0; p < NP; p++) begin                                  // R9
            r[8*p+0] = m_sts[p][16];
            r[8*p+1] = m_sts[p][1];
            r[8*p+2] = m_sts[p][11];
            r[8*p+4] = m_sts[p][10];
            r[8*p+5] = m_sts[p][8];
        end
        return r & m_en;
    endfunction

    function automatic logic [31:0] exp_read(int a);
        if (a < NP)  return m_sts[a];
        if (a == 4)  return exp_pend();
        if (a == 5)  return m_en;
        return '0;
    endfunction

    task automatic check_all();
        logic [31:0] e;
        reg_we = 1'b0;
        for (int a = 0; a < 8; a++) begin
            reg_addr = 3'(a);
            #1;
            e = exp_read(a);
            n_chk++;
            if (reg_rdata !== e) begin
                n_bad++;
                if (a < NP)
                    $display("FAIL R1 R2 R3 R4 R5 R6 R7 R8 port %0d status: actual %h expected %h", a, reg_rdata, e);
                else if (a == 4)
                    $display("FAIL R9 pending word: actual %h expected %h", reg_rdata, e);
                else
                    $display("FAIL R11 address %0d: actual %h expected %h", a, reg_rdata, e);
            end
        end
        n_chk++;
        if (irq !== (|exp_pend())) begin
            n_bad++;
            $display("FAIL R10 irq: actual %b expected %b", irq, |exp_pend());
        end
    endtask

    // one cycle: check after the previous edge, then drive for the next edge
    task automatic step(input logic we, input logic [2:0] a, input logic [31:0] wd,
                        input logic [3:0] ff, input logic [3:0] fr, input logic [3:0] ig);
        @(negedge clk);
        check_all();
        #2;
        reg_we = we; reg_addr = a; reg_wdata = wd;
        fifo_err = ff; frm_err = fr; integ_err = ig;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0, '0, '0, '0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R2: links 0 and 2 ready while reset is held; reset state checked (R8)
        phy_rdy = 4'b0101;
        sig_det = 4'b0011;
        @(negedge clk); check_all();
        @(negedge clk); check_all();
        rst_n = 1'b1;
        idle(4);
        // R7: clear everything, then collide a clear with new events on link 1
        step(1'b1, 3'd0, 32'hFFFF_FFFF, '0, '0, '0);
        step(1'b1, 3'd1, 32'hFFFF_FFFF, 4'b0010, 4'b0010, 4'b0010);
        step(1'b1, 3'd1, 32'h0000_0000, '0, '0, '0);
        // R11: enable everything, R9/R10 observed through pending and irq
        step(1'b1, 3'd5, 32'hFFFF_FFFF, '0, '0, '0);
        step(1'b1, 3'd4, 32'hFFFF_FFFF, '0, '0, '0);
        // R1/R2: drop ready on link 0 (change only), raise link 3 (both)
        phy_rdy = 4'b1100;
        idle(4);
        // R6: lose signal on link 0, write 1 to bit 9
        sig_det = 4'b0010;
        idle(3);
        step(1'b1, 3'd0, 32'h0000_0200, '0, '0, '0);
        idle(2);
        // R3/R4/R5 single pulses per link
        step(1'b0, 3'd0, '0, 4'b0100, '0, '0);
        step(1'b0, 3'd0, '0, '0, 4'b1000, '0);
        step(1'b0, 3'd0, '0, '0, '0, 4'b0001);
        idle(2);
        // random phase
        for (int c = 0; c < NCYC; c++) begin
            logic [3:0] ff, fr, ig;
            logic we;
            logic [31:0] wd;
            for (int p = 0; p < NP; p++) begin
                if ($urandom % 16 == 0) phy_rdy[p] = ~phy_rdy[p];
                if ($urandom % 16 == 0) sig_det[p] = ~sig_det[p];
                ff[p] = ($urandom % 8 == 0);
                fr[p] = ($urandom % 8 == 0);
                ig[p] = ($urandom % 8 == 0);
            end
            we = ($urandom % 3 == 0);
            wd = ($urandom % 2 == 0) ? 32'hFFFF_FFFF : $urandom;
            step(we, 3'($urandom % 8), wd, ff, fr, ig);
        end
        idle(1);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule